// File: doc/BRIEF.md
# Sequenced Four-Channel PWM Generator

This block drives four PWM outputs. It takes each period's duty and output polarity from a small sequence memory that the host fills through a simple write port. A free-running counter, slowed by a power-of-two prescaler, counts from zero up to a programmable top value, and each full count is one PWM period. At every period boundary the block moves its sequence pointer. A step in a sequence holds one 16-bit word per channel. Two sequences play back to back. Each value can be repeated for extra periods, an idle gap can follow each sequence, and the pair of sequences repeats a programmed number of times.

Control is by single-cycle task pulses: start and stop. Progress is reported by single-cycle event pulses for period end, sequence start, sequence end, loops done and stopped. An optional short turns loops-done into a stop request. This makes a whole multiplexed frame, such as digit strobes together with segment drives, play in hardware without any software timing.

Top module: `seqpwm4`

## Requirements
- R1: A sequence word holds the polarity in bit 15 and the compare value C in bits 14..0. Each output is high while the counter is below C when the polarity is 0, and is the inverse of that when the polarity is 1. For polarity 0 this gives min(C, top+1)·2^P high cycles in each period, where P is the prescale setting.
- R2: One period lasts (top+1)·2^P clock cycles. A top value below 3 acts as 3. Each period ends with a one-cycle `ev_period_end` pulse.
- R3: The memory word for channel ch of step st in sequence s sits at address (s·STEPS + st)·4 + ch. A step loads all four channels together. The configuration writes (`wr_cfg`=1) decode `wr_addr[2:0]` as follows: 0 top, 1 prescale exponent, 2 sequence-0 length, 3 sequence-1 length, 4 refresh count, 5 end delay, 6 loop count, 7 short enable in bit 0.
- R4: With refresh count F, each step's values are used for F+1 consecutive periods.
- R5: Sequence 0 plays, then sequence 1. A length of 0 acts as 1 and a length above STEPS acts as STEPS. `ev_seq_start` pulses when a sequence begins, and `seq_id` names the sequence that is playing. `ev_seq_end` pulses at the boundary that ends a sequence's last value.
- R6: With end delay D greater than zero, D idle periods follow each sequence. During these periods every output sits at its idle level.
- R7: After the pair has played N times, `ev_loops_done` pulses once, with N = 0 treated as 1. The outputs then go to their idle level while periods keep running.
- R8: When the short is enabled, loops-done requests a stop, and the block halts at the following period boundary.
- R9: `task_stop` takes effect at the next period boundary. `ev_stopped` pulses in the same cycle as that boundary's `ev_period_end`. After that, no period events occur, and each output holds its idle level, which equals its last loaded polarity bit.
- R10: A `task_start` pulse while the block is running has no effect on the output waveforms or the event pulses.
- R11: Compare and polarity values change only at period boundaries, so an output changes level at most once within a period.
- R12: After reset the outputs are low and all event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_cfg | input | 1 | 1 selects a configuration register, 0 selects the sequence memory |
| wr_addr | input | $clog2(2·STEPS·NCH) | Write address |
| wr_data | input | 16 | Write data |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| pwm_out | output | NCH | PWM outputs |
| seq_id | output | 1 | Sequence currently playing |
| ev_period_end | output | 1 | Period-end event |
| ev_seq_start | output | 1 | Sequence-start event |
| ev_seq_end | output | 1 | Sequence-end event |
| ev_loops_done | output | 1 | Loop count reached |
| ev_stopped | output | 1 | Block halted |

## Verification
The assertions check the event relationships on every cycle. Sequence-end, loops-done and stopped only ever fire together with a period end. Two period ends never fall on adjacent cycles. Nothing follows a stop, and the outputs stay frozen while the block is idle. Several behaviours can only be shown by the bench's scenarios, because they depend on programmed memory contents and counts over many periods. These are the per-period high time of each channel, the period length under clamping, the order of steps, refresh repeats, idle gaps, the loop count, the effect of the short, and the fact that an extra start leaves playback unchanged.

// File: rtl/seqpwm4.sv
module seqpwm4 #(
  parameter int NCH    = 4,
  parameter int STEPS  = 4,
  parameter int PRE_W  = 3,
  parameter int REF_W  = 8,
  parameter int DLY_W  = 8,
  parameter int LOOP_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              wr_cfg,
  input  logic [$clog2(2*STEPS*NCH)-1:0]    wr_addr,
  input  logic [15:0]                       wr_data,
  input  logic                              task_start,
  input  logic                              task_stop,
  output logic [NCH-1:0]                    pwm_out,
  output logic                              seq_id,
  output logic                              ev_period_end,
  output logic                              ev_seq_start,
  output logic                              ev_seq_end,
  output logic                              ev_loops_done,
  output logic                              ev_stopped
);
  localparam int MEMN = 2*STEPS*NCH;
  localparam int AW   = $clog2(MEMN);
  localparam int SW   = $clog2(STEPS);
  localparam int LW   = $clog2(STEPS+1);
  localparam int PCW  = (1 << PRE_W) - 1;

  typedef enum logic [1:0] {PH_PLAY, PH_DELAY, PH_HOLD} phase_t;

  logic [15:0]       mem [MEMN];
  logic [14:0]       top_r;
  logic [PRE_W-1:0]  pre_r;
  logic [LW-1:0]     len0_r, len1_r;
  logic [REF_W-1:0]  ref_r;
  logic [DLY_W-1:0]  dly_r;
  logic [LOOP_W-1:0] loops_r;
  logic              short_r;

  logic              run, stop_pend;
  logic [14:0]       cnt;
  logic [PCW-1:0]    pre_cnt;
  logic [14:0]       cmp [NCH];
  logic [NCH-1:0]    pol;
  logic              seq;
  logic [SW-1:0]     step;
  logic [REF_W-1:0]  rep;
  logic [DLY_W-1:0]  dcnt;
  logic [LOOP_W-1:0] loop;
  phase_t            phase;

  logic              n_seq;
  logic [SW-1:0]     n_step;
  logic [REF_W-1:0]  n_rep;
  logic [DLY_W-1:0]  n_dcnt;
  logic [LOOP_W-1:0] n_loop;
  phase_t            n_phase;
  logic              do_load, do_idle, do_stop, set_pend, adv;
  logic              e_sstart, e_send, e_ldone;

  function automatic logic [SW-1:0] last_of(input logic [LW-1:0] l);
    if (l == '0)                return '0;
    else if (int'(l) > STEPS)   return SW'(STEPS-1);
    else                        return SW'(l - 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !wr_cfg) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_r   <= 15'd255;
      pre_r   <= '0;
      len0_r  <= LW'(STEPS);
      len1_r  <= LW'(STEPS);
      ref_r   <= '0;
      dly_r   <= '0;
      loops_r <= LOOP_W'(1);
      short_r <= 1'b0;
    end else if (wr_en && wr_cfg) begin
      case (wr_addr[2:0])
        3'd0: top_r   <= wr_data[14:0];
        3'd1: pre_r   <= wr_data[PRE_W-1:0];
        3'd2: len0_r  <= wr_data[LW-1:0];
        3'd3: len1_r  <= wr_data[LW-1:0];
        3'd4: ref_r   <= wr_data[REF_W-1:0];
        3'd5: dly_r   <= wr_data[DLY_W-1:0];
        3'd6: loops_r <= wr_data[LOOP_W-1:0];
        default: short_r <= wr_data[0];
      endcase
    end
  end

  logic [14:0]    top_eff;
  logic [PCW-1:0] pmask;
  logic           tick, bnd;
  logic [SW-1:0]  last_step;
  logic           loops_met;

  assign top_eff   = (top_r < 15'd3) ? 15'd3 : top_r;
  assign pmask     = PCW'((1 << pre_r) - 1);
  assign tick      = (pre_cnt & pmask) == pmask;
  assign bnd       = run && tick && (cnt >= top_eff);
  assign last_step = last_of(seq ? len1_r : len0_r);
  assign loops_met = ({1'b0, loop} + 1'b1) >=
                     ((loops_r == '0) ? (LOOP_W+1)'(1) : {1'b0, loops_r});

  always_comb begin
    n_seq = seq; n_step = step; n_rep = rep; n_dcnt = dcnt;
    n_loop = loop; n_phase = phase;
    do_load = 1'b0; do_idle = 1'b0; do_stop = 1'b0; set_pend = 1'b0; adv = 1'b0;
    e_sstart = 1'b0; e_send = 1'b0; e_ldone = 1'b0;
    if (stop_pend) begin
      do_stop = 1'b1;
    end else begin
      case (phase)
        PH_PLAY: begin
          if (rep < ref_r) n_rep = rep + 1'b1;
          else begin
            n_rep = '0;
            if (step != last_step) begin
              n_step  = step + 1'b1;
              do_load = 1'b1;
            end else begin
              e_send = 1'b1;
              if (dly_r != '0) begin
                n_phase = PH_DELAY;
                n_dcnt  = '0;
                do_idle = 1'b1;
              end else adv = 1'b1;
            end
          end
        end
        PH_DELAY: begin
          if (dcnt == dly_r - 1'b1) adv = 1'b1;
          else n_dcnt = dcnt + 1'b1;
        end
        default: ;
      endcase
      if (adv) begin
        if (!seq) begin
          n_seq = 1'b1; n_step = '0; n_phase = PH_PLAY;
          do_load = 1'b1; e_sstart = 1'b1;
        end else if (loops_met) begin
          e_ldone = 1'b1; n_phase = PH_HOLD; do_idle = 1'b1;
          set_pend = short_r;
        end else begin
          n_loop = loop + 1'b1; n_seq = 1'b0; n_step = '0; n_phase = PH_PLAY;
          do_load = 1'b1; e_sstart = 1'b1;
        end
      end
    end
  end

  logic          ld_seq;
  logic [SW-1:0] ld_step;
  logic [AW-1:0] base;
  logic [15:0]   rd [NCH];

  assign ld_seq  = run ? n_seq  : 1'b0;
  assign ld_step = run ? n_step : '0;
  assign base    = AW'((int'(ld_seq) * STEPS + int'(ld_step)) * NCH);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign rd[g]      = mem[base + AW'(g)];
    assign pwm_out[g] = pol[g] ^ (cnt < cmp[g]);
  end

  assign seq_id = seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; stop_pend <= 1'b0; cnt <= '0; pre_cnt <= '0;
      for (int i = 0; i < NCH; i++) cmp[i] <= '0;
      pol <= '0; seq <= 1'b0; step <= '0; rep <= '0; dcnt <= '0; loop <= '0;
      phase <= PH_PLAY;
      ev_period_end <= 1'b0; ev_seq_start <= 1'b0; ev_seq_end <= 1'b0;
      ev_loops_done <= 1'b0; ev_stopped <= 1'b0;
    end else begin
      ev_period_end <= 1'b0; ev_seq_start <= 1'b0; ev_seq_end <= 1'b0;
      ev_loops_done <= 1'b0; ev_stopped <= 1'b0;
      if (!run) begin
        if (task_start) begin
          run <= 1'b1; stop_pend <= 1'b0; cnt <= '0; pre_cnt <= '0;
          seq <= 1'b0; step <= '0; rep <= '0; dcnt <= '0; loop <= '0;
          phase <= PH_PLAY;
          for (int i = 0; i < NCH; i++) begin
            pol[i] <= rd[i][15];
            cmp[i] <= rd[i][14:0];
          end
          ev_seq_start <= 1'b1;
        end
      end else begin
        if (task_stop) stop_pend <= 1'b1;
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) cnt <= (cnt >= top_eff) ? '0 : cnt + 1'b1;
        if (bnd) begin
          ev_period_end <= 1'b1;
          ev_seq_start  <= e_sstart;
          ev_seq_end    <= e_send;
          ev_loops_done <= e_ldone;
          seq <= n_seq; step <= n_step; rep <= n_rep; dcnt <= n_dcnt;
          loop <= n_loop; phase <= n_phase;
          if (set_pend) stop_pend <= 1'b1;
          for (int i = 0; i < NCH; i++) begin
            if (do_load) begin
              pol[i] <= rd[i][15];
              cmp[i] <= rd[i][14:0];
            end else if (do_idle || do_stop) begin
              cmp[i] <= '0;
            end
          end
          if (do_stop) begin
            run <= 1'b0; stop_pend <= 1'b0; cnt <= '0;
            ev_stopped <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/seqpwm4_chk.sv
module seqpwm4_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [NCH-1:0] pwm_out,
  input logic           ev_period_end,
  input logic           ev_seq_start,
  input logic           ev_seq_end,
  input logic           ev_loops_done,
  input logic           ev_stopped
);
  a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stopped |-> ev_period_end);

  a_r9_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stopped |=> (!ev_period_end && !run));

  a_r5_seq_end_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_end |-> ev_period_end);

  a_r7_loops_done_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ev_loops_done |-> (ev_period_end && !ev_seq_start));

  a_r2_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    ev_period_end |=> !ev_period_end);

  a_r12_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> $stable(pwm_out));
endmodule

bind seqpwm4 seqpwm4_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pwm_out(pwm_out),
  .ev_period_end(ev_period_end), .ev_seq_start(ev_seq_start),
  .ev_seq_end(ev_seq_end), .ev_loops_done(ev_loops_done),
  .ev_stopped(ev_stopped)
);

// File: tb/tb_seqpwm4.sv
`timescale 1ns/1ps
module tb_seqpwm4;
  localparam int NCH = 4, STEPS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_cfg = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic task_start = 1'b0, task_stop = 1'b0;
  logic [NCH-1:0] pwm_out;
  logic seq_id, ev_period_end, ev_seq_start, ev_seq_end, ev_loops_done, ev_stopped;

  always #2.5 clk = ~clk;

  seqpwm4 dut (.*);

  int vecs = 0, errs = 0;
  bit fin = 0;
  logic [15:0] memv [32];
  logic [63:0] exp_q [$];
  int topb, preb, body_n;

  bit arm = 0, mon_on = 0;
  int n_pe, n_ss, n_se, n_ld, n_st, widx;
  int wlen, hi [NCH], tr [NCH];
  logic [NCH-1:0] prev;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int lclamp(input int l);
    return (l == 0) ? 1 : ((l > STEPS) ? STEPS : l);
  endfunction

  function automatic logic [63:0] idle_of(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int c = 0; c < NCH; c++) r[c*16+15] = v[c*16+15];
    return r;
  endfunction

  // expected per-period channel words (R1, R3, R4, R5, R6, R7)
  task automatic build_expect(input int l0, input int l1, input int rf, input int dl, input int lp);
    logic [63:0] last = '0;
    int le = (lp == 0) ? 1 : lp;
    exp_q.delete();
    for (int k = 0; k < le; k++)
      for (int s = 0; s < 2; s++) begin
        int n = lclamp(s ? l1 : l0);
        for (int st = 0; st < n; st++) begin
          logic [63:0] v;
          for (int c = 0; c < NCH; c++) v[c*16 +: 16] = memv[(s*STEPS + st)*NCH + c];
          for (int r = 0; r <= rf; r++) exp_q.push_back(v);
          last = v;
        end
        for (int d = 0; d < dl; d++) exp_q.push_back(idle_of(last));
      end
    body_n = exp_q.size();
    for (int h = 0; h < 40; h++) exp_q.push_back(idle_of(last));
  endtask

  task automatic close_win();
    logic [63:0] e = (widx < exp_q.size()) ? exp_q[widx] : '0;
    int L = (topb + 1) << preb;
    chk(wlen == L, "R2", $sformatf("period length win %0d", widx), wlen, L);
    for (int c = 0; c < NCH; c++) begin
      int cv = int'(e[c*16 +: 15]);
      int h0 = ((cv > topb + 1) ? topb + 1 : cv) << preb;
      int he = e[c*16+15] ? L - h0 : h0;
      chk(hi[c] == he, "R1", $sformatf("high cycles ch%0d win %0d", c, widx), hi[c], he);
      chk(tr[c] <= 1, "R11", $sformatf("level changes ch%0d win %0d", c, widx), tr[c], 1);
    end
    widx++;
  endtask

  always @(negedge clk) begin
    if (arm) begin
      if (ev_period_end) n_pe++;
      if (ev_seq_start)  n_ss++;
      if (ev_seq_end)    n_se++;
      if (ev_loops_done) n_ld++;
      if (ev_stopped)    n_st++;
      if (mon_on && ev_period_end) begin
        close_win();
        wlen = 0;
        for (int c = 0; c < NCH; c++) begin hi[c] = 0; tr[c] = 0; end
      end
      if (ev_stopped) mon_on = 0;
      else if (!mon_on && ev_seq_start) begin
        mon_on = 1; wlen = 0;
        for (int c = 0; c < NCH; c++) begin hi[c] = 0; tr[c] = 0; end
      end
      if (mon_on) begin
        for (int c = 0; c < NCH; c++) begin
          if (pwm_out[c]) hi[c]++;
          if (wlen > 0 && pwm_out[c] != prev[c]) tr[c]++;
        end
        prev = pwm_out;
        wlen++;
      end
    end
  end

  task automatic tick1();
    @(negedge clk); #1;
  endtask

  task automatic wr(input bit cfg, input int a, input int d);
    tick1();
    wr_en = 1'b1; wr_cfg = cfg; wr_addr = 5'(a); wr_data = 16'(d);
    tick1();
    wr_en = 1'b0; wr_cfg = 1'b0;
  endtask

  task automatic pulse_start();
    task_start = 1'b1; tick1(); task_start = 1'b0;
  endtask

  task automatic setup(input int top, input int pre, input int l0, input int l1,
                       input int rf, input int dl, input int lp, input bit sh);
    topb = (top < 3) ? 3 : top; preb = pre;
    for (int a = 0; a < 32; a++) begin
      memv[a] = {1'($urandom % 2), 15'($urandom % (topb + 3))};
      wr(0, a, int'(memv[a]));
    end
    wr(1, 0, top); wr(1, 1, pre); wr(1, 2, l0); wr(1, 3, l1);
    wr(1, 4, rf);  wr(1, 5, dl);  wr(1, 6, lp); wr(1, 7, int'(sh));
    build_expect(l0, l1, rf, dl, lp);
    n_pe = 0; n_ss = 0; n_se = 0; n_ld = 0; n_st = 0; widx = 0; mon_on = 0;
    arm = 1;
  endtask

  task automatic check_idle_after(input string req);
    logic [63:0] e = (widx > 0) ? exp_q[widx-1] : '0;
    logic [NCH-1:0] ip;
    int pe0 = n_pe;
    for (int c = 0; c < NCH; c++) ip[c] = e[c*16+15];
    repeat (20) tick1();
    chk(pwm_out == ip, req, "idle level after stop", int'(pwm_out), int'(ip));
    chk(n_pe == pe0, req, "period events after stop", n_pe - pe0, 0);
    arm = 0;
  endtask

  task automatic run_case(input int top, input int pre, input int l0, input int l1,
                          input int rf, input int dl, input int lp, input bit sh);
    int le = (lp == 0) ? 1 : lp;
    int target;
    setup(top, pre, l0, l1, rf, dl, lp, sh);
    pulse_start();
    while (n_ld == 0) begin
      task_start = ($urandom % 150 == 0);   // R10: ignored while running
      tick1();
    end
    task_start = 1'b0;
    if (!sh) begin
      target = n_pe + 3;                     // R7: periods continue after loops done
      while (n_pe < target) tick1();
      repeat (2) tick1();
      task_stop = 1'b1; tick1(); task_stop = 1'b0;
    end
    while (n_st == 0) tick1();
    chk(widx == body_n + (sh ? 1 : 4), sh ? "R8" : "R7", "period count", widx, body_n + (sh ? 1 : 4));
    chk(n_ss == 2*le, "R5", "sequence starts", n_ss, 2*le);
    chk(n_se == 2*le, "R5", "sequence ends", n_se, 2*le);
    chk(n_ld == 1, "R7", "loops done pulses", n_ld, 1);
    chk(n_st == 1, "R9", "stopped pulses", n_st, 1);
    check_idle_after("R9");
  endtask

  initial begin
    void'($urandom(32'h5EC4));
    repeat (4) tick1();
    // R12: reset state
    chk(pwm_out == '0, "R12", "outputs in reset", int'(pwm_out), 0);
    chk({ev_period_end, ev_seq_start, ev_seq_end, ev_loops_done, ev_stopped} == '0,
        "R12", "events in reset", 1, 0);
    rst_n = 1'b1;
    repeat (3) tick1();
    chk(pwm_out == '0, "R12", "outputs after reset", int'(pwm_out), 0);

    // R2 and R5 clamps: top 1 -> 3, length 0 -> 1, length 7 -> 4
    run_case(1, 1, 0, 7, 0, 1, 1, 1);
    // R6 with end delays, R4 with refresh, R8 short
    run_case(6, 0, 2, 3, 2, 2, 2, 1);
    // R7 without short: hold then stop task
    run_case(5, 1, 1, 2, 0, 0, 2, 0);
    // R7: loop count 0 acts as 1
    run_case(4, 0, 3, 1, 1, 0, 0, 1);

    for (int k = 0; k < 10; k++)
      run_case(3 + $urandom % 10, $urandom % 3, 1 + $urandom % 4, 1 + $urandom % 4,
               $urandom % 2, $urandom % 3, 1 + $urandom % 3, 1'($urandom % 2));

    // R9 / R10 directed: stop mid-period, extra start mid-run
    setup(5, 0, 4, 4, 0, 0, 5, 0);
    pulse_start();
    while (n_pe < 2) tick1();
    repeat (2) tick1();
    pulse_start();
    while (n_pe < 3) tick1();
    repeat (2) tick1();
    task_stop = 1'b1; tick1(); task_stop = 1'b0;
    while (n_st == 0) tick1();
    chk(n_pe == 4, "R9", "stop at next boundary", n_pe, 4);
    chk(n_ss == 1, "R10", "start while running ignored", n_ss, 1);
    chk(widx == 4, "R9", "windows before stop", widx, 4);
    check_idle_after("R9");

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule